// File: doc/BRIEF.md
# BIOS ROM Sector Access Lock Controller

This block sits beside the host-to-ROM path and decides, for every host access aimed at firmware ROM space, whether that access may proceed. The topmost megabyte of the address map is cut into sixteen 64 KB sectors, each guarded by its own 4-bit lock field. One further field guards the lower firmware area from FFC0_0000h to FFEF_FFFFh. Accesses to the legacy low window 000C_0000h–000F_FFFFh are first folded onto FFFC_0000h–FFFF_FFFFh, and the folded address picks the lock field.

Within each field, two low bits deny reads and writes. Two sticky high bits can only be set, never cleared by software, and they control who may still change the low bits: one limits changes to system management mode (SMM), the other freezes them. A global sticky bit limits every change to the lock registers, and to the external range-decode register, to SMM. The SMM state is followed by watching special-cycle data words. All state is cleared by the bus reset.

Software reaches the lock registers through a simple word-wide configuration port. Reads of the port are combinational and always allowed. Writes that the lock hierarchy forbids are dropped without any notice.

Top module: `bios_rom_guard`

## Requirements
- R1: After reset every lock field, the global lock and the SMM flag are 0, so all configuration words read back as 0.
- R2: A special cycle whose data is 0005_0002h sets the SMM flag, and one whose data is 0006_0002h clears it. Any other data leaves the flag alone. The new state governs from the next cycle on.
- R3: Configuration word 0 holds the fields of sectors 0–7, and word 1 holds those of sectors 8–15. Sector i sits at bits 4(i mod 8)+3:4(i mod 8). In word 2, bits 3:0 hold the rest-of-ROM field and bit 4 holds the global lock. Unused bits and word 3 read as 0, and writes to word 3 do nothing.
- R4: Field bits 2 and 3 and the global lock bit are set by writing 1. Writing 0 leaves them unchanged, and only reset clears them.
- R5: While a field's bit 3 is 1, its bits 1:0 cannot change in any mode.
- R6: While a field's bit 3 is 0 and bit 2 is 1, its bits 1:0 change only if a write arrives while in SMM.
- R7: While the global lock is 1 and SMM is 0, configuration writes are dropped entirely. The output `decode_wr_ok` is 1 exactly when the global lock is 0 or SMM is 1.
- R8: For BIOS-flagged accesses, an address in FFF0_0000h–FFFF_FFFFh uses the sector field chosen by address bits 19:16. An address in 000C_0000h–000F_FFFFh uses sector 12 + bits 17:16. An address in FFC0_0000h–FFEF_FFFFh uses the rest-of-ROM field. Any other address has no lock field.
- R9: A BIOS-flagged read is denied exactly when the selected field's bit 0 is 1.
- R10: A BIOS-flagged write is allowed exactly when the selected field's bit 1 is 0 and `rom_wr_en` is 1. An address with no field counts as having bit 1 equal to 0.
- R11: An access not flagged as BIOS space is always allowed, whatever the lock bits are.
- R12: `acc_allow` is combinational in the same cycle as `acc_valid` and is 0 when `acc_valid` is 0. Configuration writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| sc_valid | input | 1 | Special-cycle data word present |
| sc_data | input | 32 | Special-cycle data word |
| acc_valid | input | 1 | Host access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| acc_is_bios | input | 1 | Address decoded as BIOS space |
| rom_wr_en | input | 1 | Global ROM write enable |
| acc_allow | output | 1 | Access is permitted |
| decode_wr_ok | output | 1 | Range-decode register may be written |

## Verification
The allow decision and the configuration read data depend only on the present inputs and the stored state, so they are due in the same cycle as their stimulus. The bench drives its inputs on the falling edge and samples shortly after, well before the next rising edge. Configuration writes and special cycles change stored state at the rising edge that follows, so their effect first shows in the next cycle. The bench updates its own model at that edge only after it has sampled the outputs for the current cycle.

// File: rtl/bios_rom_guard.sv
module bios_rom_guard #(
  parameter logic [31:0] SMM_ENTER_WORD = 32'h0005_0002,
  parameter logic [31:0] SMM_EXIT_WORD  = 32'h0006_0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        sc_valid,
  input  logic [31:0] sc_data,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic        acc_is_bios,
  input  logic        rom_wr_en,
  output logic        acc_allow,
  output logic        decode_wr_ok
);

  logic [15:0][3:0] sec_q;
  logic [3:0]       rest_q;
  logic             glk_q;
  logic             smm_q;

  function automatic logic [3:0] merge(input logic [3:0] cur, input logic [3:0] nw, input logic smm);
    logic [3:0] r;
    r[3:2] = cur[3:2] | nw[3:2];
    r[1:0] = (!cur[3] && (!cur[2] || smm)) ? nw[1:0] : cur[1:0];
    return r;
  endfunction

  assign decode_wr_ok = !glk_q || smm_q;
  wire   reg_wr = cfg_we && decode_wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      rest_q <= '0;
      glk_q  <= 1'b0;
      smm_q  <= 1'b0;
    end else begin
      if (sc_valid && sc_data == SMM_ENTER_WORD) smm_q <= 1'b1;
      else if (sc_valid && sc_data == SMM_EXIT_WORD) smm_q <= 1'b0;
      if (reg_wr) begin
        case (cfg_addr)
          2'd0: for (int i = 0; i < 8; i++) sec_q[i] <= merge(sec_q[i], cfg_wdata[4*i +: 4], smm_q);
          2'd1: for (int i = 0; i < 8; i++) sec_q[8+i] <= merge(sec_q[8+i], cfg_wdata[4*i +: 4], smm_q);
          2'd2: begin
            rest_q <= merge(rest_q, cfg_wdata[3:0], smm_q);
            glk_q  <= glk_q | cfg_wdata[4];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = sec_q[7:0];
      2'd1:    cfg_rdata = sec_q[15:8];
      2'd2:    cfg_rdata = {27'd0, glk_q, rest_q};
      default: cfg_rdata = '0;
    endcase
  end

  wire       in_low  = acc_addr[31:18] == 14'h0003;
  wire       in_top  = in_low || acc_addr[31:20] == 12'hFFF;
  wire       in_rest = acc_addr[31:22] == 10'h3FF && acc_addr[21:20] != 2'b11;
  wire [3:0] sec_ix  = in_low ? {2'b11, acc_addr[17:16]} : acc_addr[19:16];
  wire [3:0] fld     = in_top ? sec_q[sec_ix] : (in_rest ? rest_q : 4'd0);
  wire       ok      = !acc_is_bios || (acc_write ? (!fld[1] && rom_wr_en) : !fld[0]);
  assign acc_allow = acc_valid && ok;

  logic [31:0] rw_bits, frz_mask;
  logic [15:0] stk_bits;
  always_comb begin
    for (int i = 0; i < 16; i++) begin
      rw_bits[2*i +: 2]  = sec_q[i][1:0];
      frz_mask[2*i +: 2] = {2{sec_q[i][3]}};
      stk_bits[i]        = sec_q[i][3] | sec_q[i][2];
    end
  end

  // R2
  smm_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid && sc_data == SMM_ENTER_WORD |=> smm_q);

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stk_bits) & ~stk_bits) == 16'd0) && !($past(glk_q) && !glk_q));

  // R5
  frozen_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rw_bits ^ $past(rw_bits)) & $past(frz_mask)) == 32'd0);

  // R7
  glock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glk_q && !smm_q |=> $stable(sec_q) && $stable(rest_q));

  // R11
  nonbios_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_is_bios |-> acc_allow);

  // R12
  idle_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_allow);

endmodule

// File: tb/bios_rom_guard_tb.sv
module bios_rom_guard_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic sc_valid = 0; logic [31:0] sc_data = 0;
  logic acc_valid = 0, acc_write = 0, acc_is_bios = 0, rom_wr_en = 0;
  logic [31:0] acc_addr = 0;
  logic acc_allow, decode_wr_ok;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bios_rom_guard u_dut (.*);

  logic [3:0] m_sec [16];
  logic [3:0] m_rest;
  logic m_glk, m_smm;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_merge(input logic [3:0] cur, input logic [3:0] nw);
    logic [3:0] r;
    r[3:2] = cur[3:2] | nw[3:2];
    r[1:0] = (cur[3] || (cur[2] && !m_smm)) ? cur[1:0] : nw[1:0];  // R5 R6
    return r;
  endfunction

  function automatic logic [31:0] m_rdata(input logic [1:0] a);
    logic [31:0] r = 0;
    if (a == 0) for (int i = 0; i < 8; i++) r[4*i +: 4] = m_sec[i];
    if (a == 1) for (int i = 0; i < 8; i++) r[4*i +: 4] = m_sec[8+i];
    if (a == 2) r = {27'd0, m_glk, m_rest};
    return r;
  endfunction

  // R8 R9 R10 R11 R12
  function automatic logic m_allow();
    logic [3:0] f = 0;
    if (acc_addr >= 32'h000C_0000 && acc_addr <= 32'h000F_FFFF) f = m_sec[12 + acc_addr[17:16]];
    else if (acc_addr >= 32'hFFF0_0000) f = m_sec[acc_addr[19:16]];
    else if (acc_addr >= 32'hFFC0_0000 && acc_addr <= 32'hFFEF_FFFF) f = m_rest;
    if (!acc_valid) return 0;
    if (!acc_is_bios) return 1;
    return acc_write ? (!f[1] && rom_wr_en) : !f[0];
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 16; i++) m_sec[i] = 0;
    m_rest = 0; m_glk = 0; m_smm = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cfg_we = 0; sc_valid = 0; acc_valid = 0;
    repeat (2) @(negedge clk);
    m_clear(); rst_n = 1;
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] wd,
                     input logic scv, input logic [31:0] scd,
                     input logic av, input logic aw, input logic [31:0] ad,
                     input logic bios, input logic rwe);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd; sc_valid = scv; sc_data = scd;
    acc_valid = av; acc_write = aw; acc_addr = ad; acc_is_bios = bios; rom_wr_en = rwe;
    #2;
    chk("R3 cfg_rdata", cfg_rdata, m_rdata(a));
    chk("R7 decode_wr_ok", {31'd0, decode_wr_ok}, {31'd0, (!m_glk || m_smm)});
    chk("R9/R10/R11 acc_allow", {31'd0, acc_allow}, {31'd0, m_allow()});
    @(posedge clk);
    if (we && (!m_glk || m_smm)) begin
      if (a == 0) for (int i = 0; i < 8; i++) m_sec[i] = m_merge(m_sec[i], wd[4*i +: 4]);
      if (a == 1) for (int i = 0; i < 8; i++) m_sec[8+i] = m_merge(m_sec[8+i], wd[4*i +: 4]);
      if (a == 2) begin m_rest = m_merge(m_rest, wd[3:0]); m_glk = m_glk | wd[4]; end
    end
    if (scv && scd == 32'h0005_0002) m_smm = 1;
    else if (scv && scd == 32'h0006_0002) m_smm = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic sc(input logic [31:0] d);
    cyc(0, 0, 0, 1, d, 0, 0, 0, 0, 0);
  endtask
  task automatic acc(input logic w, input logic [31:0] ad, input logic rwe);
    cyc(0, 2'd0, 0, 0, 0, 1, w, ad, 1, rwe);
  endtask

  function automatic logic [31:0] rand_addr();
    case ($urandom % 6)
      0: return 32'hFFF0_0000 | ($urandom & 32'h000F_FFFF);
      1: return 32'h000C_0000 | ($urandom & 32'h0003_FFFF);
      2: return 32'hFFC0_0000 + ($urandom % 32'h0030_0000);
      3: return 32'hFFBF_FFFF - ($urandom % 16);
      4: return 32'h000B_FFF0 + ($urandom % 32);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_clear();
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) cyc(0, a[1:0], 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 R12 non-BIOS and idle
    cyc(0, 0, 0, 0, 0, 1, 1, 32'hFFFF_0000, 0, 0);
    // R3 word layout and word 3 ignored
    wr(2'd0, 32'h3210_3210); wr(2'd1, 32'h0123_0123); wr(2'd3, 32'hFFFF_FFFF);
    for (int a = 0; a < 4; a++) cyc(0, a[1:0], 0, 0, 0, 0, 0, 0, 0, 0);
    // R8 R9 R10 low-window fold, sector select, rest range, edges
    wr(2'd1, 32'h3120_0000); wr(2'd2, 32'h0000_0003);
    acc(0, 32'h000E_1234, 1); acc(1, 32'h000D_0000, 1); acc(1, 32'h000F_FFFF, 1);
    acc(0, 32'hFFFE_0000, 1); acc(0, 32'hFFEF_FFFF, 1); acc(0, 32'hFFC0_0000, 1);
    acc(0, 32'hFFBF_FFFF, 1); acc(1, 32'hFFF0_0000, 0); acc(0, 32'h000B_FFFF, 1);
    // R2 R6 SMM-only change
    wr(2'd0, 32'h0000_0400); wr(2'd0, 32'h0000_0300);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    sc(32'h0005_0002); sc(32'h1234_5678);
    wr(2'd0, 32'h0000_0500);
    sc(32'h0006_0002); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4 R5 freeze and sticky
    wr(2'd1, 32'h8000_0000); wr(2'd1, 32'h3000_0000);
    sc(32'h0005_0002); wr(2'd1, 32'h0000_0000); cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 global lock
    wr(2'd2, 32'h0000_0010); sc(32'h0006_0002);
    wr(2'd0, 32'hFFFF_FFFF); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    sc(32'h0005_0002); wr(2'd0, 32'h0000_0001); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 reset clears sticky state
    do_reset();
    for (int a = 0; a < 3; a++) cyc(0, a[1:0], 0, 0, 0, 0, 0, 0, 0, 0);
    // random mix covering R2 through R12
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d, s;
      if (n % 400 == 399) do_reset();
      d = $urandom;
      if ($urandom % 3 != 0) d = d & 32'h3333_3333;
      case ($urandom % 4)
        0: s = 32'h0005_0002;
        1: s = 32'h0006_0002;
        default: s = $urandom;
      endcase
      cyc(($urandom % 3) == 0, 2'($urandom), d, ($urandom % 4) == 0, s,
          ($urandom % 5) != 0, 1'($urandom), rand_addr(), ($urandom % 5) != 0, ($urandom % 4) != 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule